// File: doc/BRIEF.md
# Protected Event Interrupt Controller

This block gathers 49 single-cycle event pulses from a display pipeline into one sticky status bit per line. Each line has an enable mask, a software set path, a software clear path, a choice of routing to the maskable request output or to the non-maskable output, and a lock bit. A locked line's status can be changed from the bus only by privileged transfers. The raw event pulses also leave the block unmasked, so a system-level interrupt controller can be used instead of the combined outputs.

Registers are reached through a small AHB-Lite slave. It always completes in zero wait states and samples the protection attribute in the address phase. Line 35 is reserved. It has no storage and never asserts anywhere.

Top module: `evt_intc_top`

## Requirements
- R1: After reset, every enable, status, route and lock bit is 0, and `irq_o` and `nmi_o` are low.
- R2: An event pulse on `evt_i[k]` sets status bit k at the clock edge where it is sampled, whether or not line k is enabled.
- R3: Writing 1s to the set words (0x10 for lines 0..31, 0x14 for lines 32..48) sets the matching status bits. Writing 0s there has no effect, and these words read as zero.
- R4: Writing 1s to the clear words (0x18, 0x1C) resets the matching status bits. These words read as zero.
- R5: Map layout: enable at 0x00/0x04, status (read-only) at 0x08/0x0C, route-to-NMI at 0x20/0x24, lock at 0x28/0x2C, and pending (status AND enable) at 0x30/0x34. The low word holds lines 0..31 in bits 31:0 and the high word holds lines 32..48 in bits 16:0. Unused bits and every offset from 0x38 to 0x5C read as zero.
- R6: `irq_o` is registered. It is high one cycle after any line has status=1, enable=1 and route=0.
- R7: `nmi_o` is registered. It is high one cycle after any line has status=1 and route=1, whatever its enable.
- R8: `trig_o` equals `evt_i` in the same cycle, with no masking and no register, except for the reserved bit.
- R9: Line 35 is reserved. Its status, enable, route, lock and trigger bits always read and drive 0, even after an event or a set write on it.
- R10: A transfer with `hprot[1]`=0 is a user transfer. User set or clear writes leave locked lines unchanged and still act on unlocked lines. Only privileged transfers can write the lock words.
- R11: If an event and a clear reach the same line at the same clock edge, the event wins and status stays 1.
- R12: A transfer starts when `hsel` is high and `htrans[1]` is high. A write takes `hwdata` in the next cycle and takes effect at the end of that cycle. Read data is valid in that same next cycle. `hreadyout` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| haddr | input | 7 | Byte address within the 0x60 window |
| hprot | input | 4 | Protection attribute; bit 1 = privileged |
| hwdata | input | 32 | Write data, data phase |
| hrdata | output | 32 | Read data, data phase |
| hreadyout | output | 1 | Transfer done (always 1) |
| evt_i | input | 49 | Event pulses, one per line |
| irq_o | output | 1 | Combined maskable request |
| nmi_o | output | 1 | Combined non-maskable request |
| trig_o | output | 49 | Unmasked event triggers |

## Verification
Several properties are checked on every cycle. The two combined outputs must follow the previous cycle's status, enable and route state. Any sampled event must leave its status bit set. The reserved line must stay silent. `trig_o` must never show more active bits than `evt_i`.

Other behaviour can only be shown by the bench's scenarios:
- the lock check against user and privileged transfers;
- the event-wins rule against a clear in the same cycle;
- set and clear writes that leave other lines untouched;
- zero reads from unused offsets;
- register layout across the two words.

// File: rtl/evt_intc_pkg.sv
package evt_intc_pkg;
  // Function selected by address bits [6:3]; bit 2 picks the half.
  typedef enum logic [3:0] {
    K_ENABLE  = 4'd0,
    K_STATUS  = 4'd1,
    K_SET     = 4'd2,
    K_CLEAR   = 4'd3,
    K_ROUTE   = 4'd4,
    K_LOCK    = 4'd5,
    K_PENDING = 4'd6
  } reg_kind_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/evt_intc_bus.sv
module evt_intc_bus #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [AW-1:0] haddr,
  input  logic [3:0]    hprot,
  output logic          dp_wr,
  output logic          dp_rd,
  output logic          dp_priv,
  output logic [AW-3:0] dp_word
);
  logic          start;
  logic          wr_n, rd_n, priv_n;
  logic [AW-3:0] word_n;

  always_comb begin
    start  = hsel & htrans[1];
    wr_n   = start & hwrite;
    rd_n   = start & ~hwrite;
    priv_n = start ? hprot[1] : dp_priv;
    word_n = start ? haddr[AW-1:2] : dp_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_wr   <= 1'b0;
      dp_rd   <= 1'b0;
      dp_priv <= 1'b0;
      dp_word <= '0;
    end else begin
      dp_wr   <= wr_n;
      dp_rd   <= rd_n;
      dp_priv <= priv_n;
      dp_word <= word_n;
    end
  end
endmodule

// File: rtl/evt_intc_regs.sv
module evt_intc_regs
  import evt_intc_pkg::*;
#(
  parameter int unsigned N    = 49,
  parameter int unsigned RSVD = 35,
  parameter int unsigned WW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_wr,
  input  logic              dp_rd,
  input  logic              dp_priv,
  input  logic [WW-1:0]     dp_word,
  input  logic [WORD_W-1:0] wdata,
  input  logic [N-1:0]      evt,
  output logic [WORD_W-1:0] rdata,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      route_q,
  output logic [N-1:0]      lock_q,
  output logic [N-1:0]      stat_q
);
  localparam int unsigned WIDE = 2 * WORD_W;
  localparam logic [N-1:0] LIVE = {N{1'b1}} ^ (N'(1) << RSVD);

  logic [3:0]      kind;
  logic            half;
  logic [WIDE-1:0] wide_data, wide_lane, wide_rd;
  logic [N-1:0]    wr_bits, lane, allow, set_ok, clr_ok;
  logic [N-1:0]    en_n, route_n, lock_n, stat_n;
  logic [N-1:0]    rd_src;

  always_comb begin
    kind      = dp_word[WW-1:1];
    half      = dp_word[0];
    wide_data = half ? {wdata, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, wdata};
    wide_lane = half ? {{WORD_W{1'b1}}, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, {WORD_W{1'b1}}};
    lane      = wide_lane[N-1:0];
    wr_bits   = wide_data[N-1:0] & LIVE;
    allow     = dp_priv ? {N{1'b1}} : ~lock_q;

    en_n    = en_q;
    route_n = route_q;
    lock_n  = lock_q;
    set_ok  = '0;
    clr_ok  = '0;
    if (dp_wr) begin
      case (kind)
        K_ENABLE: en_n    = (en_q & ~lane) | (wr_bits & lane);
        K_ROUTE:  route_n = (route_q & ~lane) | (wr_bits & lane);
        K_LOCK:   if (dp_priv) lock_n = (lock_q & ~lane) | (wr_bits & lane);
        K_SET:    set_ok  = wr_bits & lane & allow;
        K_CLEAR:  clr_ok  = wr_bits & lane & allow;
        default:  ;
      endcase
    end
    // Event or set beats a simultaneous clear.
    stat_n = (evt | set_ok | (stat_q & ~clr_ok)) & LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      lock_q  <= '0;
    end else if (dp_wr) begin
      en_q    <= en_n;
      route_q <= route_n;
      lock_q  <= lock_n;
    end
  end

  // One sticky flop per line; the reserved line has none.
  for (genvar k = 0; k < N; k++) begin : g_stat
    if (k == RSVD) begin : g_rsvd
      assign stat_q[k] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[k] <= 1'b0;
        else        stat_q[k] <= stat_n[k];
      end
    end
  end

  always_comb begin
    case (kind)
      K_ENABLE:  rd_src = en_q;
      K_STATUS:  rd_src = stat_q;
      K_ROUTE:   rd_src = route_q;
      K_LOCK:    rd_src = lock_q;
      K_PENDING: rd_src = stat_q & en_q;
      default:   rd_src = '0;
    endcase
    wide_rd = WIDE'(rd_src);
    if (!dp_rd)     rdata = '0;
    else if (half)  rdata = wide_rd[WIDE-1:WORD_W];
    else            rdata = wide_rd[WORD_W-1:0];
  end
endmodule

// File: rtl/evt_intc_merge.sv
module evt_intc_merge #(
  parameter int unsigned N = 49
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  input  logic [N-1:0] route,
  output logic         irq_q,
  output logic         nmi_q
);
  logic irq_n, nmi_n;

  always_comb begin
    irq_n = |(stat & en & ~route);
    nmi_n = |(stat & route);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
      nmi_q <= nmi_n;
    end
  end
endmodule

// File: rtl/evt_intc_top.sv
module evt_intc_top
  import evt_intc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 49,
  parameter int unsigned RSVD_LINE = 35,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsel,
  input  logic [1:0]           htrans,
  input  logic                 hwrite,
  input  logic [ADDR_W-1:0]    haddr,
  input  logic [3:0]           hprot,
  input  logic [WORD_W-1:0]    hwdata,
  output logic [WORD_W-1:0]    hrdata,
  output logic                 hreadyout,
  input  logic [NUM_LINES-1:0] evt_i,
  output logic                 irq_o,
  output logic                 nmi_o,
  output logic [NUM_LINES-1:0] trig_o
);
  localparam int unsigned WW = ADDR_W - 2;
  localparam logic [NUM_LINES-1:0] LIVE = {NUM_LINES{1'b1}} ^ (NUM_LINES'(1) << RSVD_LINE);

  logic                 dp_wr, dp_rd, dp_priv;
  logic [WW-1:0]        dp_word;
  logic [NUM_LINES-1:0] en_w, route_w, lock_w, stat_w;

  evt_intc_bus #(.AW(ADDR_W)) bus_i (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
    .haddr(haddr), .hprot(hprot), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_priv(dp_priv), .dp_word(dp_word)
  );

  evt_intc_regs #(.N(NUM_LINES), .RSVD(RSVD_LINE), .WW(WW)) regs_i (
    .clk(clk), .rst_n(rst_n), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_priv(dp_priv),
    .dp_word(dp_word), .wdata(hwdata), .evt(evt_i), .rdata(hrdata),
    .en_q(en_w), .route_q(route_w), .lock_q(lock_w), .stat_q(stat_w)
  );

  evt_intc_merge #(.N(NUM_LINES)) merge_i (
    .clk(clk), .rst_n(rst_n), .stat(stat_w), .en(en_w), .route(route_w),
    .irq_q(irq_o), .nmi_q(nmi_o)
  );

  assign trig_o    = evt_i & LIVE;
  assign hreadyout = 1'b1;
endmodule

// File: rtl/evt_intc_chk.sv
module evt_intc_chk #(
  parameter int unsigned N    = 49,
  parameter int unsigned RSVD = 35
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_i,
  input logic [N-1:0] trig_o,
  input logic         irq_o,
  input logic         nmi_o,
  input logic [N-1:0] stat,
  input logic [N-1:0] en,
  input logic [N-1:0] route
);
  localparam logic [N-1:0] LIVE = {N{1'b1}} ^ (N'(1) << RSVD);

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == (|($past(stat & en & ~route))))); // R6
  AST_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (nmi_o == (|($past(stat & route))))); // R7
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stat & $past(evt_i & LIVE)) == $past(evt_i & LIVE))); // R2
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[RSVD] == 1'b0) && (trig_o[RSVD] == 1'b0) && (en[RSVD] == 1'b0)); // R9
  AST_TRIG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(trig_o) <= $countones(evt_i)); // R8
endmodule

bind evt_intc_top evt_intc_chk #(.N(NUM_LINES), .RSVD(RSVD_LINE)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .trig_o(trig_o), .irq_o(irq_o),
  .nmi_o(nmi_o), .stat(stat_w), .en(en_w), .route(route_w)
);

// File: tb/evt_intc_tb.sv
module evt_intc_top_tb_top;
  localparam int NL = 49;
  localparam logic [NL-1:0] LIVE = {NL{1'b1}} ^ (NL'(1) << 35);

  logic          clk, rst_n, hsel, hwrite, hreadyout, irq_o, nmi_o;
  logic [1:0]    htrans;
  logic [6:0]    haddr;
  logic [3:0]    hprot;
  logic [31:0]   hwdata, hrdata;
  logic [NL-1:0] evt_i, trig_o;

  evt_intc_top dut_i (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
    .haddr(haddr), .hprot(hprot), .hwdata(hwdata), .hrdata(hrdata),
    .hreadyout(hreadyout), .evt_i(evt_i), .irq_o(irq_o), .nmi_o(nmi_o),
    .trig_o(trig_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [NL-1:0] m_en, m_st, m_rt, m_pr;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read's data phase follows its address phase by one edge.
  always @(posedge clk) rd_pend <= hsel && htrans[1] && !hwrite;
  always @(negedge clk) begin
    if (rd_pend === 1'b1) begin
      if (exp_q.size() == 0) chk("R12 unexpected read", 64'(hrdata), 64'hx);
      else chk(tag_q.pop_front(), 64'(hrdata), 64'(exp_q.pop_front()));
    end
  end

  function automatic logic [31:0] half_of(input logic [NL-1:0] v, input bit hi);
    logic [63:0] w;
    w = 64'(v);
    return hi ? w[63:32] : w[31:0];
  endfunction

  task automatic bus_rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    hsel = 1; htrans = 2'b10; hwrite = 0; haddr = a; hprot = 4'b0011;
    @(negedge clk);
    hsel = 0; htrans = 2'b00;
    @(negedge clk);
  endtask

  // kind: 0 enable,2 set,3 clear,4 route,5 lock. Model updated per requirements.
  task automatic reg_wr(input int kind, input bit hi, input logic [31:0] d,
                        input bit priv, input logic [NL-1:0] evt_dp);
    logic [63:0] wide, lanew;
    logic [NL-1:0] w, l, allow, s, c;
    wide  = hi ? {d, 32'h0} : {32'h0, d};
    lanew = hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
    w = wide[NL-1:0] & LIVE;
    l = lanew[NL-1:0];
    allow = priv ? {NL{1'b1}} : ~m_pr;
    s = '0; c = '0;
    case (kind)
      0: m_en = (m_en & ~l) | (w & l);
      4: m_rt = (m_rt & ~l) | (w & l);
      5: if (priv) m_pr = (m_pr & ~l) | (w & l);
      2: s = w & l & allow;
      3: c = w & l & allow;
      default: ;
    endcase
    m_st = (evt_dp & LIVE) | s | (m_st & ~c);
    @(negedge clk);
    hsel = 1; htrans = 2'b10; hwrite = 1; haddr = 7'(kind * 8 + (hi ? 4 : 0));
    hprot = {2'b00, priv, 1'b1};
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwrite = 0; hwdata = d; evt_i = evt_dp;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse(input logic [NL-1:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
    m_st = m_st | (v & LIVE);
  endtask

  task automatic chk_outs(input string tag);
    @(negedge clk);
    chk({tag, " irq"}, 64'(irq_o), 64'(|(m_st & m_en & ~m_rt)));
    chk({tag, " nmi"}, 64'(nmi_o), 64'(|(m_st & m_rt)));
  endtask

  task automatic rd_stat(input string tag);
    bus_rd(7'h08, half_of(m_st, 0), {tag, " status lo"});
    bus_rd(7'h0C, half_of(m_st, 1), {tag, " status hi"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    hsel = 0; htrans = 0; hwrite = 0; haddr = 0; hprot = 0; hwdata = 0; evt_i = '0;
    m_en = '0; m_st = '0; m_rt = '0; m_pr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 nmi", 64'(nmi_o), 0);
    chk("R12 ready", 64'(hreadyout), 1);
    rd_stat("R1");
    bus_rd(7'h00, 0, "R1 enable lo");
    bus_rd(7'h2C, 0, "R1 lock hi");

    // R2 event on disabled line sets status, no irq
    pulse(NL'(1) << 5);
    rd_stat("R2");
    chk_outs("R2");

    // R6 enable line 5 -> irq
    reg_wr(0, 0, 32'h0000_0020, 1, '0);
    chk_outs("R6");
    bus_rd(7'h00, 32'h20, "R5 enable lo readback");
    bus_rd(7'h30, 32'h20, "R5 pending lo");

    // R4 clear line 5 (unlocked, user)
    reg_wr(3, 0, 32'h0000_0020, 0, '0);
    rd_stat("R4");
    chk_outs("R4");
    bus_rd(7'h18, 0, "R4 clear word reads zero");

    // R3 set line 40 (hi bit 8), then enable
    reg_wr(2, 1, 32'h0000_0100, 0, '0);
    rd_stat("R3");
    bus_rd(7'h10, 0, "R3 set word reads zero");
    reg_wr(0, 1, 32'h0000_0100, 0, '0);
    chk_outs("R6 hi line");
    bus_rd(7'h34, 32'h100, "R5 pending hi");

    // R7 route line 40 to NMI, then disable: NMI stays
    reg_wr(4, 1, 32'h0000_0100, 1, '0);
    chk_outs("R7 routed");
    reg_wr(0, 1, 32'h0, 1, '0);
    chk_outs("R7 disabled");
    bus_rd(7'h24, 32'h100, "R5 route hi readback");

    // R8 trigger bypass, same cycle
    @(negedge clk);
    evt_i = (NL'(1) << 0) | (NL'(1) << 48) | (NL'(1) << 35) | (NL'(1) << 20);
    #1 chk("R8 trig", 64'(trig_o), 64'((NL'(1) << 0) | (NL'(1) << 48) | (NL'(1) << 20)));
    @(negedge clk);
    evt_i = '0;
    m_st = m_st | (LIVE & ((NL'(1) << 0) | (NL'(1) << 48) | (NL'(1) << 20)));
    rd_stat("R2 multi");

    // R9 reserved line: event and set do nothing
    pulse(NL'(1) << 35);
    reg_wr(2, 1, 32'h0000_0008, 1, '0);
    reg_wr(0, 1, 32'h0000_0008, 1, '0);
    rd_stat("R9");
    bus_rd(7'h04, 0, "R9 enable bit reads zero");

    // R10 lock line 40 (priv), user clear ignored, priv clear works
    reg_wr(5, 1, 32'h0000_0100, 1, '0);
    bus_rd(7'h2C, 32'h100, "R10 lock readback");
    reg_wr(3, 1, 32'h0001_0100, 0, '0);  // also clears unlocked line 48
    rd_stat("R10 user clear");
    chk_outs("R10 user clear");
    reg_wr(5, 1, 32'h0, 0, '0);          // user write to lock ignored
    bus_rd(7'h2C, 32'h100, "R10 lock kept");
    reg_wr(3, 1, 32'h0000_0100, 1, '0);
    rd_stat("R10 priv clear");
    reg_wr(2, 1, 32'h0000_0100, 0, '0);  // user set on locked line ignored
    rd_stat("R10 user set");
    chk_outs("R10 user set");

    // R11 event beats clear in same cycle (line 7)
    reg_wr(3, 0, 32'h0000_0080, 0, NL'(1) << 7);
    rd_stat("R11");

    // R5 unused offsets and status read-only
    reg_wr(1, 0, 32'hFFFF_FFFF, 1, '0);
    rd_stat("R5 status write ignored");
    bus_rd(7'h38, 0, "R5 offset 0x38");
    bus_rd(7'h5C, 0, "R5 offset 0x5C");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule